// File: doc/BRIEF.md
# Bipolar Two-Layer Port Classifier

This block is the inference path of a small two-layer network that turns a 32-bit destination address into an output port number. Each address bit acts as a bipolar input of +1 or -1. A hidden layer forms biased weighted sums of these inputs and maps each sum onto a five-level activation. An output layer repeats the same steps over the hidden levels. The port is the output neuron with the highest level.

Weights and the four activation thresholds sit in registers. Software fills them through a write port, one word per cycle. Lookups are fully pipelined: one address can enter on every clock, and its port appears three cycles later. The block contains no training logic and no floating-point arithmetic. All arithmetic is signed fixed point with 16-bit weights.

Top module: `port_classifier_net`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_port` is 0 until the first lookup completes. All weights and thresholds reset to 0.
- R2: Hidden unit j sums its bias (column 0) and, for c = 1..32, +w[j][c] when address bit 32-c is 1 and -w[j][c] when that bit is 0. Column 1 is therefore the address MSB.
- R3: Every pre-activation sum, hidden or output, saturates to the signed 16-bit range [-32768, 32767] before the activation is applied.
- R4: The activation compares the saturated sum s with thresholds t0..t3. The result is -1 if s < t0, -0.5 if s < t1, 0 if s < t2, +0.5 if s < t3, and +1 otherwise. A sum equal to a threshold takes the higher level.
- R5: The output pre-activation of neuron k is bias[k] + sum over j of level[j]*w[k][j+1], rounded toward minus infinity. Here level[j] is the hidden level in steps of 0.5.
- R6: `out_port` is the index of the output neuron with the largest activation level. When levels are equal, the lowest index wins.
- R7: A lookup presented with `in_valid` high at a rising edge produces `out_valid` high with its port exactly three rising edges later. A new lookup may be presented on every cycle, and `out_valid` is low three edges after a cycle with `in_valid` low.
- R8: The load port writes `wld_data` when `wld_en` is high. With `wld_sel`=0 it writes hidden weight (row, col), where col 0 is the bias and cols 1..32 are address bits. With `wld_sel`=1 it writes output weight (row, col), where col 0 is the bias and col j+1 is hidden unit j. With `wld_sel`=2 it writes threshold t[col] for col 0..3, and row is ignored. The value is used by lookups presented from the next cycle on.
- R9: A write whose row or col lies outside the selected array, or whose `wld_sel` is 3, changes no stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address on `in_addr` is a lookup this cycle |
| in_addr | input | 32 | Destination address |
| wld_en | input | 1 | Write strobe for the load port |
| wld_sel | input | 2 | Target: 0 hidden weights, 1 output weights, 2 thresholds |
| wld_row | input | 4 | Neuron index within the target |
| wld_col | input | 6 | Weight column or threshold index |
| wld_data | input | 16 | Signed value to write |
| out_valid | output | 1 | `out_port` holds a completed lookup |
| out_port | output | 3 | Selected output port |

## Verification
The assertions assume that `in_valid` is never unknown after reset. They also assume that weights and thresholds stay unchanged while a lookup is in the pipeline, since the three stages read the registers at different edges. The stimulus meets these assumptions by leaving three idle cycles before every group of writes and by issuing lookups only after the writes are done. During lookup traffic, the stimulus varies back-to-back valid cycles, random gaps, exact threshold hits, saturated sums and full ties.

// File: rtl/port_classifier_net.sv
module port_classifier_net #(
  parameter int N_IN  = 32,
  parameter int N_HID = 10,
  parameter int N_OUT = 8,
  parameter int WW    = 16
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                in_valid,
  input  logic [N_IN-1:0]                                     in_addr,
  input  logic                                                wld_en,
  input  logic [1:0]                                          wld_sel,
  input  logic [$clog2(N_HID > N_OUT ? N_HID : N_OUT)-1:0]    wld_row,
  input  logic [$clog2(N_IN+1)-1:0]                           wld_col,
  input  logic [WW-1:0]                                       wld_data,
  output logic                                                out_valid,
  output logic [$clog2(N_OUT)-1:0]                            out_port
);
  localparam int NIC   = N_IN + 1;
  localparam int NHC   = N_HID + 1;
  localparam int PW    = $clog2(N_OUT);
  localparam int RW    = $clog2(N_HID > N_OUT ? N_HID : N_OUT);
  localparam int CW    = $clog2(NIC);
  localparam int AW    = WW + $clog2(NIC + NHC) + 3;
  localparam int SMAXI = (1 << (WW-1)) - 1;
  localparam int SMINI = -(1 << (WW-1));

  typedef logic signed [WW-1:0] w_t;
  typedef logic signed [AW-1:0] acc_t;
  typedef logic signed [2:0]    lvl_t;

  w_t   wh [N_HID][NIC];
  w_t   wo [N_OUT][NHC];
  w_t   thr [4];

  acc_t hacc [N_HID];
  w_t   hpre [N_HID];
  lvl_t hlev [N_HID];
  acc_t oacc [N_OUT];
  w_t   opre [N_OUT];
  lvl_t olev [N_OUT];
  lvl_t olq  [N_OUT];
  logic v1, v2;
  logic [PW-1:0] best;

  function automatic w_t sat(input acc_t x);
    if (x > acc_t'(SMAXI))      return w_t'(SMAXI);
    else if (x < acc_t'(SMINI)) return w_t'(SMINI);
    else                        return w_t'(x);
  endfunction

  function automatic lvl_t act(input w_t s);
    if (s < thr[0])      return -3'sd2;
    else if (s < thr[1]) return -3'sd1;
    else if (s < thr[2]) return 3'sd0;
    else if (s < thr[3]) return 3'sd1;
    else                 return 3'sd2;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_HID; r++)
        for (int c = 0; c < NIC; c++) wh[r][c] <= '0;
      for (int r = 0; r < N_OUT; r++)
        for (int c = 0; c < NHC; c++) wo[r][c] <= '0;
      for (int c = 0; c < 4; c++) thr[c] <= '0;
    end else if (wld_en) begin
      for (int r = 0; r < N_HID; r++)
        for (int c = 0; c < NIC; c++)
          if (wld_sel == 2'd0 && wld_row == RW'(r) && wld_col == CW'(c)) wh[r][c] <= wld_data;
      for (int r = 0; r < N_OUT; r++)
        for (int c = 0; c < NHC; c++)
          if (wld_sel == 2'd1 && wld_row == RW'(r) && wld_col == CW'(c)) wo[r][c] <= wld_data;
      for (int c = 0; c < 4; c++)
        if (wld_sel == 2'd2 && wld_col == CW'(c)) thr[c] <= wld_data;
    end
  end

  always_comb begin
    for (int j = 0; j < N_HID; j++) begin
      hacc[j] = acc_t'(wh[j][0]);
      for (int i = 0; i < N_IN; i++)
        hacc[j] = in_addr[N_IN-1-i] ? hacc[j] + acc_t'(wh[j][i+1])
                                    : hacc[j] - acc_t'(wh[j][i+1]);
    end
  end

  always_comb
    for (int j = 0; j < N_HID; j++) hlev[j] = act(hpre[j]);

  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      oacc[k] = acc_t'(wo[k][0]) <<< 1;
      for (int j = 0; j < N_HID; j++)
        oacc[k] = oacc[k] + acc_t'(hlev[j]) * acc_t'(wo[k][j+1]);
    end
  end

  always_comb begin
    lvl_t bl;
    for (int k = 0; k < N_OUT; k++) olev[k] = act(opre[k]);
    best = '0;
    bl   = olev[0];
    for (int k = 1; k < N_OUT; k++)
      if (olev[k] > bl) begin
        best = PW'(k);
        bl   = olev[k];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
      out_port  <= '0;
      for (int j = 0; j < N_HID; j++) hpre[j] <= '0;
      for (int k = 0; k < N_OUT; k++) begin
        opre[k] <= '0;
        olq[k]  <= '0;
      end
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      for (int j = 0; j < N_HID; j++) hpre[j] <= sat(hacc[j]);
      for (int k = 0; k < N_OUT; k++) opre[k] <= sat(oacc[k] >>> 1);
      if (v2) begin
        out_port <= best;
        for (int k = 0; k < N_OUT; k++) olq[k] <= olev[k];
      end
    end
  end

  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  // R7
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);
  // R8
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wld_en && wld_sel == 2'd2 && wld_col == '0) |=> thr[0] == $past(wld_data));

  for (genvar k = 0; k < N_OUT; k++) begin : g_pick
    // R6
    max_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> olq[out_port] >= olq[k]);
    // R6
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && PW'(k) < out_port) |-> olq[k] < olq[out_port]);
  end
endmodule

// File: tb/port_classifier_net_tb.sv
module port_classifier_net_tb_top;
  localparam int CLK_P = 10;
  localparam int NI = 32, NH = 10, NO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic wld_en = 1'b0;
  logic [1:0] wld_sel = '0;
  logic [3:0] wld_row = '0;
  logic [5:0] wld_col = '0;
  logic [15:0] wld_data = '0;
  logic out_valid;
  logic [2:0] out_port;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  int mh [NH][NI+1];
  int mo [NO][NH+1];
  int mt [4];
  int q[$];

  always #(CLK_P/2) clk = ~clk;

  port_classifier_net dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .wld_en(wld_en), .wld_sel(wld_sel), .wld_row(wld_row), .wld_col(wld_col),
    .wld_data(wld_data), .out_valid(out_valid), .out_port(out_port));

  function automatic int satf(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int lvl(int s);
    if (s < mt[0]) return -2;
    if (s < mt[1]) return -1;
    if (s < mt[2]) return 0;
    if (s < mt[3]) return 1;
    return 2;
  endfunction

  function automatic int ref_port(logic [31:0] a);
    int h [NH];
    int s, bp, bl, o;
    for (int j = 0; j < NH; j++) begin
      s = mh[j][0];
      for (int i = 0; i < NI; i++) s += a[31-i] ? mh[j][i+1] : -mh[j][i+1];
      h[j] = lvl(satf(s));
    end
    bp = 0; bl = -99;
    for (int k = 0; k < NO; k++) begin
      s = 2 * mo[k][0];
      for (int j = 0; j < NH; j++) s += h[j] * mo[k][j+1];
      s = s >>> 1;
      o = lvl(satf(s));
      if (o > bl) begin bl = o; bp = k; end
    end
    return bp;
  endfunction

  task automatic step(input bit v, input logic [31:0] a, input bit le,
                      input int sel, input int row, input int col, input int data);
    int e;
    @(negedge clk);
    e = q.pop_front();
    checks++;
    if (out_valid !== e[4] || (e[4] && out_port !== e[2:0])) begin
      fails++;
      $display("FAIL %s: valid/port %0b/%0d expected %0b/%0d", cur_req,
               out_valid, out_port, e[4], e[2:0]);
    end
    in_valid = v; in_addr = a;
    wld_en = le; wld_sel = sel[1:0]; wld_row = row[3:0]; wld_col = col[5:0];
    wld_data = data[15:0];
    if (le) begin
      if (sel == 0 && row < NH && col <= NI) mh[row][col] = data;
      if (sel == 1 && row < NO && col <= NH) mo[row][col] = data;
      if (sel == 2 && col < 4) mt[col] = data;
    end
    q.push_back(v ? (16 + ref_port(a)) : 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int sel, input int row, input int col, input int data);
    step(0, '0, 1, sel, row, col, data);
  endtask

  task automatic look(input logic [31:0] a);
    step(1, a, 0, 0, 0, 0, 0);
  endtask

  task automatic set_thr(input int a, input int b, input int c, input int d);
    idle(3);
    wr(2, 0, 0, a); wr(2, 0, 1, b); wr(2, 0, 2, c); wr(2, 0, 3, d);
  endtask

  task automatic clear_all();
    idle(3);
    for (int r = 0; r < NH; r++) for (int c = 0; c <= NI; c++) wr(0, r, c, 0);
    for (int r = 0; r < NO; r++) for (int c = 0; c <= NH; c++) wr(1, r, c, 0);
  endtask

  task automatic rand_load(input int span);
    idle(3);
    for (int r = 0; r < NH; r++)
      for (int c = 0; c <= NI; c++) wr(0, r, c, int'($urandom_range(2*span)) - span);
    for (int r = 0; r < NO; r++)
      for (int c = 0; c <= NH; c++) wr(1, r, c, int'($urandom_range(2*span)) - span);
  endtask

  task automatic rand_traffic(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(3) != 0) look($urandom);
      else idle(1);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NH; r++) for (int c = 0; c <= NI; c++) mh[r][c] = 0;
    for (int r = 0; r < NO; r++) for (int c = 0; c <= NH; c++) mo[r][c] = 0;
    for (int c = 0; c < 4; c++) mt[c] = 0;
    repeat (3) q.push_back(0);

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_port !== 3'd0) begin
      fails++;
      $display("FAIL R1: valid/port %0b/%0d expected 0/0", out_valid, out_port);
    end
    rst_n = 1'b1;
    idle(4);

    // R6: all levels equal with reset weights, lowest index wins
    cur_req = "R6";
    look(32'h0); look(32'hFFFF_FFFF); look(32'h1234_5678); idle(3);

    // R2 and R4 and R5: directed sign select, bit order, threshold edges
    cur_req = "R2";
    set_thr(-1000, -400, 400, 1000);
    wr(0, 0, 1, 800);  wr(1, 3, 1, 3000);
    wr(0, 1, 32, 800); wr(1, 5, 2, 3000);
    look(32'h8000_0000); look(32'h7FFF_FFFF); look(32'h0000_0001); look(32'hC400_0000);
    idle(3);
    cur_req = "R4";
    wr(0, 2, 0, 400); wr(1, 6, 3, 1000); wr(1, 6, 0, 200);
    look(32'h0000_0000); look(32'h8000_0001); idle(3);
    cur_req = "R5";
    wr(1, 4, 0, -1); wr(1, 4, 1, 401);
    look(32'h8000_0000); look(32'h0000_0000); look(32'h8000_0001); idle(3);

    // R3: saturation of hidden and output sums
    cur_req = "R3";
    set_thr(-1000, -400, 400, 32767);
    for (int c = 0; c <= NI; c++) wr(0, 2, c, 32000);
    wr(1, 7, 3, 32767); wr(1, 7, 0, 32767);
    look(32'hFFFF_FFFF); look(32'h0000_0000); look(32'hFFFF_0000); idle(3);

    // R9: out-of-range writes leave every stored value alone
    cur_req = "R9";
    wr(0, 10, 0, 20000); wr(0, 15, 3, 20000); wr(0, 0, 33, 20000);
    wr(1, 8, 0, 32767); wr(1, 0, 11, 32767);
    wr(3, 0, 0, -32768); wr(2, 5, 4, 32767);
    look(32'hFFFF_FFFF); look(32'h0000_0000); look(32'h8000_0001); look(32'h7FFF_FFFE);
    idle(3);

    // R7 and R8: back-to-back random traffic under random weight sets
    cur_req = "R7";
    clear_all();
    set_thr(-6000, -1500, 1500, 6000);
    rand_load(2000);
    for (int i = 0; i < 400; i++) look($urandom);
    rand_traffic(1500);
    cur_req = "R8";
    rand_load(9000);
    set_thr(-20000, -3000, 3000, 20000);
    rand_traffic(1500);
    set_thr(-500, -100, 100, 500);
    rand_traffic(1000);
    idle(4);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule